// File: doc/BRIEF.md
# Dual-Request Interrupt Controller

This block gathers 32 interrupt inputs and presents them to a processor as two request lines. Every source has its own trigger configuration (held in three configuration bit-planes), an enable mask, a routing bit that picks which request line it feeds, a source-select bit that attaches or detaches the input, and a wake enable. The raw inputs are asynchronous. They pass through a two-flop synchroniser before level or edge detection.

Software reaches every control register through a small word-addressed register bus. Each control register has two aliases. Writing ones through the set alias turns bits on, and writing ones through the clear alias turns bits off, so no read-modify-write is ever needed. Two read-only registers show the pending sources for each request line. A wake output lets a pending, enabled and wake-enabled source rouse an idle processor.

Reads are combinational from `rd_addr_i`. Writes take effect at the clock edge on which `wr_en_i` is high.

Top module: `icu_dual_req`

## Requirements
- R1: After reset every readable register (word addresses 0 to 17) reads 0, and `irq_o` and `wake_o` are low.
- R2: Each control register occupies a pair of word addresses, with the set alias at the even address and the clear alias at the odd one. Writing to the set alias ORs the data into the register. Writing to the clear alias removes the data bits from the register. Bits written as 0 are unchanged. The pairs are: config-plane 0 at 0/1, config-plane 1 at 2/3, config-plane 2 at 4/5, route at 6/7, source-select at 8/9, mask at 10/11 and wake-enable at 12/13.
- R3: The trigger code of source n is {plane2[n], plane1[n], plane0[n]}. Code 101 is active-high level and code 110 is active-low level. In these modes the source status follows the input and appears two clock edges after the input changes.
- R4: Code 001 latches rising edges, code 010 latches falling edges and code 011 latches both. The edge latches read at word address 14 (and also at 15). Writing ones to address 14 or 15 clears the corresponding latches. A latch is also dropped whenever its source leaves the edge modes.
- R5: Codes 000, 100 and 111 disable a source: it never becomes pending.
- R6: A source with route bit 1 feeds request 0, and one with route bit 0 feeds request 1. Word address 16 reads the pending set for request 0 and address 17 the set for request 1. `irq_o[k]` is high exactly when pending register k is non-zero.
- R7: A source is pending only while its mask bit is set.
- R8: A source whose source-select bit is 0 is detached and never pending.
- R9: `wake_o` is high when `cpu_idle_i` is high and at least one pending source has its wake-enable bit set.
- R10: A read of a clear alias returns the same value as a read of its set alias.
- R11: A mask clear followed at once by a mask set does not lose a still-asserted level request, nor a latched edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_src_i | input | 32 | Raw asynchronous interrupt inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 5 | Register read word address |
| rd_data_o | output | 32 | Register read data |
| cpu_idle_i | input | 1 | Processor is idle |
| irq_o | output | 2 | Request lines (bit 0 = request 0) |
| wake_o | output | 1 | Wake request |

## Verification
If a configuration bit-plane is corrupted, the source decodes to the wrong trigger. Its pending bit and request line are then wrong two to three edges after the next input change, and its alias reads are wrong at once. An edge latch that sticks or never sets shows in the pending registers and at address 14 three edges after the edge. A routing or mask fault shows on `irq_o` in the same cycle as the register update. Sweeping all eight trigger codes with several input patterns drives each of these faults to the ports.

// File: rtl/icu_pkg.sv
package icu_pkg;
    // Trigger codes: {plane2, plane1, plane0}
    typedef enum logic [2:0] {
        TRG_OFF    = 3'b000,
        TRG_RISE   = 3'b001,
        TRG_FALL   = 3'b010,
        TRG_BOTH   = 3'b011,
        TRG_LVL_HI = 3'b101,
        TRG_LVL_LO = 3'b110
    } trig_e;

    // Register pair indices (word address >> 1)
    localparam int IDX_CFG0   = 0;
    localparam int IDX_CFG1   = 1;
    localparam int IDX_CFG2   = 2;
    localparam int IDX_ROUTE  = 3;
    localparam int IDX_SRCSEL = 4;
    localparam int IDX_MASK   = 5;
    localparam int IDX_WAKE   = 6;
    localparam int IDX_LATCH  = 7;
    localparam int IDX_PEND   = 8;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = async_i;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sync_o = s_q.sync;
    assign prev_o = s_q.prev;
endmodule

// File: rtl/icu_trigger.sv
module icu_trigger
    import icu_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] plane0_i,
    input  logic [NSRC-1:0] plane1_i,
    input  logic [NSRC-1:0] plane2_i,
    input  logic [NSRC-1:0] cur_i,
    input  logic [NSRC-1:0] prev_i,
    output logic [NSRC-1:0] level_hit_o,
    output logic [NSRC-1:0] edge_ev_o,
    output logic [NSRC-1:0] edge_mode_o
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [2:0] code;
        assign code = {plane2_i[i], plane1_i[i], plane0_i[i]};

        always_comb begin
            level_hit_o[i] = 1'b0;
            edge_ev_o[i]   = 1'b0;
            edge_mode_o[i] = 1'b0;
            case (code)
                TRG_LVL_HI: level_hit_o[i] = cur_i[i];
                TRG_LVL_LO: level_hit_o[i] = ~cur_i[i];
                TRG_RISE: begin
                    edge_mode_o[i] = 1'b1;
                    edge_ev_o[i]   = cur_i[i] & ~prev_i[i];
                end
                TRG_FALL: begin
                    edge_mode_o[i] = 1'b1;
                    edge_ev_o[i]   = ~cur_i[i] & prev_i[i];
                end
                TRG_BOTH: begin
                    edge_mode_o[i] = 1'b1;
                    edge_ev_o[i]   = cur_i[i] ^ prev_i[i];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/icu_dual_req.sv
module icu_dual_req
    import icu_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 5
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] irq_src_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [NSRC-1:0] wr_data_i,
    input  logic [AW-1:0]   rd_addr_i,
    output logic [NSRC-1:0] rd_data_o,
    input  logic            cpu_idle_i,
    output logic [1:0]      irq_o,
    output logic            wake_o
);
    localparam int IW = AW - 1;

    typedef struct packed {
        logic [NSRC-1:0] cfg0;
        logic [NSRC-1:0] cfg1;
        logic [NSRC-1:0] cfg2;
        logic [NSRC-1:0] route;
        logic [NSRC-1:0] srcsel;
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] wake;
        logic [NSRC-1:0] lat;
    } state_t;

    state_t st_d, st_q;

    logic [NSRC-1:0] cur, prev, level_hit, edge_ev, edge_mode;
    logic [NSRC-1:0] lat_clr, status, pend0, pend1;

    function automatic logic [NSRC-1:0] apply_alias(
        input logic [NSRC-1:0] val, input logic is_clr, input logic [NSRC-1:0] d);
        return is_clr ? (val & ~d) : (val | d);
    endfunction

    icu_sync #(.W(NSRC)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (irq_src_i),
        .sync_o  (cur),
        .prev_o  (prev)
    );

    icu_trigger #(.NSRC(NSRC)) i_trig (
        .plane0_i    (st_q.cfg0),
        .plane1_i    (st_q.cfg1),
        .plane2_i    (st_q.cfg2),
        .cur_i       (cur),
        .prev_i      (prev),
        .level_hit_o (level_hit),
        .edge_ev_o   (edge_ev),
        .edge_mode_o (edge_mode)
    );

    always_comb begin
        st_d    = st_q;
        lat_clr = '0;
        if (wr_en_i) begin
            case (wr_addr_i[AW-1:1])
                IW'(IDX_CFG0):   st_d.cfg0   = apply_alias(st_q.cfg0,   wr_addr_i[0], wr_data_i);
                IW'(IDX_CFG1):   st_d.cfg1   = apply_alias(st_q.cfg1,   wr_addr_i[0], wr_data_i);
                IW'(IDX_CFG2):   st_d.cfg2   = apply_alias(st_q.cfg2,   wr_addr_i[0], wr_data_i);
                IW'(IDX_ROUTE):  st_d.route  = apply_alias(st_q.route,  wr_addr_i[0], wr_data_i);
                IW'(IDX_SRCSEL): st_d.srcsel = apply_alias(st_q.srcsel, wr_addr_i[0], wr_data_i);
                IW'(IDX_MASK):   st_d.mask   = apply_alias(st_q.mask,   wr_addr_i[0], wr_data_i);
                IW'(IDX_WAKE):   st_d.wake   = apply_alias(st_q.wake,   wr_addr_i[0], wr_data_i);
                IW'(IDX_LATCH):  lat_clr     = wr_data_i;
                default: ;
            endcase
        end
        // a new edge wins over a simultaneous clear so no event is lost
        st_d.lat = ((st_q.lat & ~lat_clr) | edge_ev) & edge_mode;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status = st_q.srcsel & (level_hit | (st_q.lat & edge_mode));
    assign pend0  = status & st_q.mask & st_q.route;
    assign pend1  = status & st_q.mask & ~st_q.route;
    assign irq_o  = {|pend1, |pend0};
    assign wake_o = cpu_idle_i & (|(status & st_q.mask & st_q.wake));

    always_comb begin
        case (rd_addr_i[AW-1:1])
            IW'(IDX_CFG0):   rd_data_o = st_q.cfg0;
            IW'(IDX_CFG1):   rd_data_o = st_q.cfg1;
            IW'(IDX_CFG2):   rd_data_o = st_q.cfg2;
            IW'(IDX_ROUTE):  rd_data_o = st_q.route;
            IW'(IDX_SRCSEL): rd_data_o = st_q.srcsel;
            IW'(IDX_MASK):   rd_data_o = st_q.mask;
            IW'(IDX_WAKE):   rd_data_o = st_q.wake;
            IW'(IDX_LATCH):  rd_data_o = st_q.lat;
            IW'(IDX_PEND):   rd_data_o = rd_addr_i[0] ? pend1 : pend0;
            default:         rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/icu_dual_req_chk.sv
module icu_dual_req_chk #(
    parameter int NSRC = 32,
    parameter int AW   = 5
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            wr_en_i,
    input logic [AW-1:0]   wr_addr_i,
    input logic [NSRC-1:0] wr_data_i,
    input logic            cpu_idle_i,
    input logic [1:0]      irq_o,
    input logic            wake_o,
    input logic [NSRC-1:0] mask,
    input logic [NSRC-1:0] cfg_any,
    input logic [NSRC-1:0] pend0,
    input logic [NSRC-1:0] pend1
);
    localparam logic [AW-1:0] A_MSET = AW'(10);
    localparam logic [AW-1:0] A_MCLR = AW'(11);

    p_mask_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_MSET) |=> ((mask & $past(wr_data_i)) == $past(wr_data_i)));

    p_mask_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == A_MCLR) |=> ((mask & $past(wr_data_i)) == '0));

    p_mask_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_en_i && wr_addr_i[AW-1:1] == A_MSET[AW-1:1]) |=> $stable(mask));

    p_disabled_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pend0 | pend1) & ~cfg_any) == '0);

    p_route_disjoint_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend0 & pend1) == '0);

    p_irq_needs_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o != 2'b00) |-> (mask != '0));

    p_wake_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> (cpu_idle_i && irq_o != 2'b00));
endmodule

bind icu_dual_req icu_dual_req_chk #(.NSRC(NSRC), .AW(AW)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .cpu_idle_i (cpu_idle_i),
    .irq_o      (irq_o),
    .wake_o     (wake_o),
    .mask       (st_q.mask),
    .cfg_any    (st_q.cfg0 | st_q.cfg1 | st_q.cfg2),
    .pend0      (pend0),
    .pend1      (pend1)
);

// File: tb/test_icu_dual_req.sv
module test_icu_dual_req;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        idle = 1'b0;
    logic [1:0]  irq;
    logic        wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] mdl_lat, route_m, mask_m, sel_m;
    logic [2:0]  mode_m;

    always #5 clk = ~clk;

    icu_dual_req i_icu_dual_req (
        .clk_i(clk), .rst_ni(rst_n), .irq_src_i(src), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .cpu_idle_i(idle), .irq_o(irq), .wake_o(wake)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = 5'(a);
        #1 d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] edge_ev(input logic [2:0] m, input logic [31:0] o, input logic [31:0] n);
        case (m)
            3'b001:  return n & ~o;
            3'b010:  return ~n & o;
            3'b011:  return n ^ o;
            default: return '0;
        endcase
    endfunction

    function automatic logic [31:0] status(input logic [2:0] m, input logic [31:0] n, input logic [31:0] l);
        case (m)
            3'b101:  return n & sel_m;
            3'b110:  return ~n & sel_m;
            3'b001, 3'b010, 3'b011: return l & sel_m;
            default: return '0;
        endcase
    endfunction

    task automatic check_pend(input string tag);
        logic [31:0] st, p0, p1, got;
        st = status(mode_m, src, mdl_lat);
        p0 = st & mask_m & route_m;
        p1 = st & mask_m & ~route_m;
        rd(16, got); chk({tag, " pend0"}, got, p0);
        rd(17, got); chk({tag, " pend1"}, got, p1);
        chk({tag, " irq"}, {30'd0, irq}, {30'd0, |p1, |p0});
    endtask

    task automatic set_mode(input logic [2:0] m);
        for (int k = 0; k < 3; k++) wr(2 * k + (m[k] ? 0 : 1), 32'hFFFF_FFFF);
        mode_m = m;
    endtask

    task automatic drive(input logic [31:0] v);
        logic [31:0] old;
        old = src;
        @(negedge clk);
        src = v;
        settle();
        mdl_lat |= edge_ev(mode_m, old, v);
    endtask

    initial begin
        logic [31:0] v, w;
        mdl_lat = '0; route_m = '0; mask_m = '0; sel_m = '0; mode_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 18; a++) begin
            rd(a, v); chk($sformatf("R1 reset addr %0d", a), v, '0);
        end
        chk("R1 reset irq/wake", {29'd0, irq, wake}, '0);

        // R2 / R10: set and clear aliases on each control register
        for (int r = 0; r < 7; r++) begin
            wr(2 * r, 32'hA5A5_3C3C);
            wr(2 * r, 32'h0000_0101);
            rd(2 * r, v); chk($sformatf("R2 set reg %0d", r), v, 32'hA5A5_3D3D);
            wr(2 * r + 1, 32'h0F0F_0101);
            rd(2 * r, v); chk($sformatf("R2 clear reg %0d", r), v, 32'hA0A0_3C3C);
            rd(2 * r + 1, w); chk($sformatf("R10 clear alias reg %0d", r), w, v);
            wr(2 * r + 1, 32'hFFFF_FFFF);
        end

        // R3 R4 R5 R6: sweep all eight trigger codes
        sel_m = '1; mask_m = '1; route_m = 32'hFFFF_0000;
        wr(8, sel_m); wr(10, mask_m); wr(6, route_m);
        for (int m = 0; m < 8; m++) begin
            set_mode(3'(m));
            drive(32'h0);
            wr(14, 32'hFFFF_FFFF);
            mdl_lat = '0;
            check_pend($sformatf("R5/R3 code %0d idle", m));
            drive(32'h3C5A_96E1);
            check_pend($sformatf("R3/R4/R6 code %0d A", m));
            drive(32'hF00F_0FF0);
            check_pend($sformatf("R3/R4/R6 code %0d B", m));
            drive(32'h0);
            check_pend($sformatf("R4/R6 code %0d C", m));
            rd(14, v); chk($sformatf("R4 latch code %0d", m), v, mdl_lat);
            wr(15, 32'h0000_FFFF);
            mdl_lat &= 32'hFFFF_0000;
            check_pend($sformatf("R4 w1c code %0d", m));
        end

        // R7 / R8 / R11 on active-high level
        set_mode(3'b101);
        mdl_lat = '0;
        drive(32'hFFFF_FFFF);
        wr(11, 32'h0000_0008); mask_m[3] = 1'b0;
        check_pend("R7 mask cleared");
        wr(10, 32'h0000_0008); mask_m[3] = 1'b1;
        check_pend("R7 mask restored");
        wr(11, 32'h0001_0008);
        wr(10, 32'h0001_0008);
        check_pend("R11 level toggle");
        rd(16, v); chk("R11 level bit16 kept", v & 32'h0001_0000, 32'h0001_0000);
        wr(9, 32'h0000_00F0); sel_m[7:4] = 4'h0;
        check_pend("R8 detached");
        wr(8, 32'h0000_00F0); sel_m[7:4] = 4'hF;
        check_pend("R8 reattached");

        // R11 on rising edge latch
        set_mode(3'b001);
        drive(32'h0);
        wr(14, 32'hFFFF_FFFF); mdl_lat = '0;
        drive(32'h0000_0100);
        wr(11, 32'h0000_0100);
        wr(10, 32'h0000_0100);
        check_pend("R11 edge toggle");
        rd(14, v); chk("R11 edge latch kept", v, 32'h0000_0100);

        // R9 wake
        set_mode(3'b101);
        wr(6, 32'hFFFF_FFFF); route_m = '1;
        drive(32'h0000_0010);
        wr(12, 32'h0000_0010);
        idle = 1'b0; @(negedge clk);
        chk("R9 wake busy", {31'd0, wake}, 32'd0);
        idle = 1'b1; @(negedge clk);
        chk("R9 wake idle", {31'd0, wake}, 32'd1);
        wr(11, 32'h0000_0010);
        chk("R9 wake masked", {31'd0, wake}, 32'd0);
        wr(10, 32'h0000_0010);
        chk("R9 wake unmasked", {31'd0, wake}, 32'd1);
        wr(13, 32'h0000_0010);
        chk("R9 wake disabled", {31'd0, wake}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule